// File: doc/BRIEF.md
# DMA Transfer Completion Event Generator

This block lives inside a DMA channel engine and watches the transfer requests that one parameter set produces. When the set is started it works out how many requests the set will issue. That number depends on the synchronization mode: one request per array in array-synchronized mode, one request per frame in frame-synchronized mode. It then follows each request as it is submitted and, unless early completion is selected, as its completion comes back. From this it decides which requests earn a completion event toward the interrupt logic.

Two option bits choose the events. One covers the final request and the other covers every intermediate request. A third bit moves the event from the completion report to the submission. Each event is a single-cycle pulse carrying the 6-bit completion code that was latched at start. In normal-completion mode a small FIFO remembers, for each outstanding request, whether it was the last one. Completions are assumed to return in submission order.

Top module: `xfer_done_evgen`

## Requirements
- R1: While `rst_n` is low at a rising edge, `evt_valid` is 0 and `evt_code` is 0 in the following cycle.
- R2: A `start` with `sync_ab`=0 arms `cnt_b`×`cnt_c` requests. A `start` with `sync_ab`=1 arms `cnt_c` requests. Only that many submissions are accepted.
- R3: With `fin_en`=1 and `mid_en`=0, exactly one event is produced per parameter set, and it belongs to the last request.
- R4: With `fin_en`=0 and `mid_en`=1, an event is produced for every request except the last (19 for 4×5 in array mode, 4 for C=5 in frame mode).
- R5: With both enables set, an event is produced for every request (20 and 5 in the cases above).
- R6: With `early_en`=1, a qualifying event appears on `evt_valid` in the cycle right after the `req_sub` strobe, and `req_cmp` has no effect.
- R7: With `early_en`=0, a qualifying event appears in the cycle right after a `req_cmp` strobe. Completions are matched to outstanding requests in submission order, and a completion in the same cycle as a submission is matched against the requests already outstanding.
- R8: While `evt_valid` is 1, `evt_code` equals the `code` sampled at the latest `start`. While `evt_valid` is 0, `evt_code` is 0.
- R9: A `start` whose request count is zero arms nothing, and no later strobe produces an event until the next `start`.
- R10: A submission beyond the armed count, and a completion with no outstanding request, are ignored.
- R11: A `start` discards outstanding requests, and a strobe in the same cycle as `start` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Latches the parameter set and arms the request count |
| sync_ab | input | 1 | 0 = one request per array, 1 = one request per frame |
| cnt_b | input | 16 | Arrays per frame |
| cnt_c | input | 16 | Frames per block |
| fin_en | input | 1 | Event for the final request |
| mid_en | input | 1 | Event for each intermediate request |
| early_en | input | 1 | 1 = event on submission, 0 = event on completion |
| code | input | 6 | Completion code reported with each event |
| req_sub | input | 1 | A request was submitted |
| req_cmp | input | 1 | The oldest outstanding request completed |
| evt_valid | output | 1 | One-cycle completion event |
| evt_code | output | 6 | Code carried by the event |

## Verification
The block is driven with a 4×5 parameter set in both synchronization modes under each of the three enable combinations. The resulting event counts (1, 19, 20 and 1, 4, 5) separate last-request detection from intermediate-request detection, and they separate array counting from frame counting. Early mode is compared with normal mode using interleaved and simultaneous strobes, which shows whether events follow the right strobe and whether the FIFO classifies completions in order. Extra strobes, zero counts and a restart with requests still outstanding exercise the rules that say when a strobe is ignored. A model that reacts on every clock checks both the exact event cycle and the code.

// File: rtl/evgen_pkg.sv
// Package: shared types for the completion event generator.
// Assumes: nothing beyond standard SystemVerilog.
package evgen_pkg;

    typedef enum logic {
        SYNC_ARRAY = 1'b0,
        SYNC_FRAME = 1'b1
    } sync_mode_e;

    // Options latched when a parameter set starts
    typedef struct packed {
        logic       fin;
        logic       mid;
        logic       early;
        logic [5:0] code;
    } evt_cfg_t;

endpackage

// File: rtl/evgen_req_counter.sv
// Module: evgen_req_counter
// Computes how many requests the parameter set issues and counts down
// on each accepted submission, marking the final one.
// Assumes: start has priority over a submission in the same cycle.
module evgen_req_counter
    import evgen_pkg::*;
#(
    parameter int CNT_W = 16,
    localparam int TOT_W = 2 * CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  sync_mode_e       mode,
    input  logic [CNT_W-1:0] cnt_b,
    input  logic [CNT_W-1:0] cnt_c,
    input  logic             sub,
    output logic             sub_ok,
    output logic             sub_last,
    output logic [TOT_W-1:0] remaining
);

    logic [TOT_W-1:0] total;
    logic [TOT_W-1:0] rem_q;

    // Request total for the selected synchronization mode
    always_comb begin
        if (mode == SYNC_FRAME)
            total = {{CNT_W{1'b0}}, cnt_c};
        else
            total = TOT_W'(cnt_b) * TOT_W'(cnt_c);
    end

    // Accept a submission only while requests remain and no start is present
    always_comb begin
        sub_ok   = sub && !start && (rem_q != '0);
        sub_last = (rem_q == TOT_W'(1));
    end

    // Load on start, decrement on each accepted submission
    always_ff @(posedge clk) begin
        if (!rst_n)
            rem_q <= '0;
        else if (start)
            rem_q <= total;
        else if (sub_ok)
            rem_q <= rem_q - TOT_W'(1);
    end

    assign remaining = rem_q;

endmodule

// File: rtl/evgen_flag_fifo.sv
// Module: evgen_flag_fifo
// Holds the last-request flag of each outstanding request in order.
// Assumes: a push while full without a pop is dropped; pop on empty is ignored.
module evgen_flag_fifo #(
    parameter int DEPTH = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic             din,
    input  logic             pop,
    output logic             pop_ok,
    output logic             dout,
    output logic [CNT_W-1:0] count
);

    logic [DEPTH-1:0] store_q;
    logic [PTR_W-1:0] rd_q;
    logic [PTR_W-1:0] wr_q;
    logic [CNT_W-1:0] cnt_q;
    logic             push_ok;

    // Qualify the strobes against occupancy
    always_comb begin
        pop_ok  = pop && !flush && (cnt_q != '0);
        push_ok = push && !flush && ((cnt_q != CNT_W'(DEPTH)) || pop_ok);
        dout    = store_q[rd_q];
    end

    // Pointer advance with wrap at DEPTH
    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        if (p == PTR_W'(DEPTH - 1))
            return '0;
        return p + PTR_W'(1);
    endfunction

    // Write a flag into its slot
    always_ff @(posedge clk) begin
        if (!rst_n)
            store_q <= '0;
        else if (push_ok)
            store_q[wr_q] <= din;
    end

    // Pointers and occupancy
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push_ok)
                wr_q <= nxt(wr_q);
            if (pop_ok)
                rd_q <= nxt(rd_q);
            case ({push_ok, pop_ok})
                2'b10:   cnt_q <= cnt_q + CNT_W'(1);
                2'b01:   cnt_q <= cnt_q - CNT_W'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign count = cnt_q;

endmodule

// File: rtl/evgen_qualifier.sv
// Module: evgen_qualifier
// Latches the options at start and turns classified requests into
// one-cycle events that carry the completion code.
// Assumes: only one of the two request paths is active, as chosen by early.
module evgen_qualifier
    import evgen_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  evt_cfg_t   cfg_in,
    input  logic       early_hit,
    input  logic       early_last,
    input  logic       norm_hit,
    input  logic       norm_last,
    output logic       early_mode,
    output logic [5:0] code_now,
    output logic       evt_valid,
    output logic [5:0] evt_code
);

    evt_cfg_t cfg_q;
    logic     hit;
    logic     is_last;
    logic     fire;

    // Latch the options of the parameter set
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (start)
            cfg_q <= cfg_in;
    end

    // Choose the path and decide whether the request earns an event
    always_comb begin
        hit     = cfg_q.early ? early_hit  : norm_hit;
        is_last = cfg_q.early ? early_last : norm_last;
        fire    = hit && !start && (is_last ? cfg_q.fin : cfg_q.mid);
    end

    // Register the event and its code
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_valid <= 1'b0;
            evt_code  <= '0;
        end else begin
            evt_valid <= fire;
            evt_code  <= fire ? cfg_q.code : 6'd0;
        end
    end

    assign early_mode = cfg_q.early;
    assign code_now   = cfg_q.code;

endmodule

// File: rtl/xfer_done_evgen.sv
// Module: xfer_done_evgen (top)
// Tracks the requests of one parameter set and emits completion events
// for the final and/or intermediate requests, on submission or completion.
// Assumes: completions return in submission order, and no more than
// FIFO_DEPTH requests are outstanding in normal-completion mode.
module xfer_done_evgen
    import evgen_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int FIFO_DEPTH = 8,
    localparam int TOT_W     = 2 * CNT_W,
    localparam int OCC_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             sync_ab,
    input  logic [CNT_W-1:0] cnt_b,
    input  logic [CNT_W-1:0] cnt_c,
    input  logic             fin_en,
    input  logic             mid_en,
    input  logic             early_en,
    input  logic [5:0]       code,
    input  logic             req_sub,
    input  logic             req_cmp,
    output logic             evt_valid,
    output logic [5:0]       evt_code
);

    logic             sub_ok;
    logic             sub_last;
    logic [TOT_W-1:0] remaining;
    logic             early_q;
    logic [5:0]       code_q;
    logic             pop_ok;
    logic             head_last;
    logic [OCC_W-1:0] occ;
    evt_cfg_t         cfg_in;
    sync_mode_e       mode;

    // Pack the start-time options
    always_comb begin
        cfg_in = '{fin: fin_en, mid: mid_en, early: early_en, code: code};
        mode   = sync_ab ? SYNC_FRAME : SYNC_ARRAY;
    end

    evgen_req_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .mode      (mode),
        .cnt_b     (cnt_b),
        .cnt_c     (cnt_c),
        .sub       (req_sub),
        .sub_ok    (sub_ok),
        .sub_last  (sub_last),
        .remaining (remaining)
    );

    evgen_flag_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk    (clk),
        .rst_n  (rst_n),
        .flush  (start),
        .push   (sub_ok && !early_q),
        .din    (sub_last),
        .pop    (req_cmp && !early_q),
        .pop_ok (pop_ok),
        .dout   (head_last),
        .count  (occ)
    );

    evgen_qualifier u_qual (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .cfg_in     (cfg_in),
        .early_hit  (sub_ok),
        .early_last (sub_last),
        .norm_hit   (pop_ok),
        .norm_last  (head_last),
        .early_mode (early_q),
        .code_now   (code_q),
        .evt_valid  (evt_valid),
        .evt_code   (evt_code)
    );

endmodule

// File: rtl/evgen_checker.sv
// Module: evgen_checker
// Temporal checks on the completion event generator, bound to the top.
module evgen_checker #(
    parameter int TOT_W = 32,
    parameter int OCC_W = 4,
    parameter int DEPTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             req_sub,
    input logic             req_cmp,
    input logic             evt_valid,
    input logic [5:0]       evt_code,
    input logic             early_q,
    input logic [5:0]       code_q,
    input logic [TOT_W-1:0] remaining,
    input logic [OCC_W-1:0] occ
);

    // R1: reset clears the event output
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!evt_valid && evt_code == 6'd0));

    // R6: in early mode every event follows a submission strobe
    a_r6_early_source: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && early_q) |-> $past(req_sub));

    // R7: in normal mode every event follows a completion with something outstanding
    a_r7_norm_source: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && !early_q) |-> ($past(req_cmp) && $past(occ) != '0));

    // R8: the event carries the latched code
    a_r8_code_match: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |-> (evt_code == code_q));

    // R10: without a start the remaining count never grows
    a_r10_no_regrow: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> (remaining <= $past(remaining)));

    // R11: a strobe alongside start yields no event
    a_r11_start_wins: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !evt_valid);

    // R7: occupancy bounded by the FIFO depth
    a_r7_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= OCC_W'(DEPTH));

endmodule

bind xfer_done_evgen evgen_checker #(
    .TOT_W (TOT_W),
    .OCC_W (OCC_W),
    .DEPTH (FIFO_DEPTH)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .req_sub   (req_sub),
    .req_cmp   (req_cmp),
    .evt_valid (evt_valid),
    .evt_code  (evt_code),
    .early_q   (early_q),
    .code_q    (code_q),
    .remaining (remaining),
    .occ       (occ)
);

// File: tb/sim_xfer_done_evgen.sv
module sim_xfer_done_evgen;

    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        sync_ab = 1'b0;
    logic [15:0] cnt_b = '0;
    logic [15:0] cnt_c = '0;
    logic        fin_en = 1'b0;
    logic        mid_en = 1'b0;
    logic        early_en = 1'b0;
    logic [5:0]  code = '0;
    logic        req_sub = 1'b0;
    logic        req_cmp = 1'b0;
    logic        evt_valid;
    logic [5:0]  evt_code;

    int tests = 0;
    int fails = 0;
    int evt_cnt = 0;
    string tag = "R1";
    bit done = 0;

    always #2 clk = ~clk;

    xfer_done_evgen u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .sync_ab(sync_ab),
        .cnt_b(cnt_b), .cnt_c(cnt_c), .fin_en(fin_en), .mid_en(mid_en),
        .early_en(early_en), .code(code), .req_sub(req_sub),
        .req_cmp(req_cmp), .evt_valid(evt_valid), .evt_code(evt_code)
    );

    // Behavioural reference model
    longint m_rem = 0;
    bit     m_fin = 0, m_mid = 0, m_early = 0;
    int     m_code = 0;
    bit     m_q[$];
    bit     exp_v = 0;
    int     exp_c = 0;

    always @(posedge clk) begin
        bit v;
        bit f;
        v = 0;
        if (!rst_n) begin
            m_rem = 0; m_fin = 0; m_mid = 0; m_early = 0; m_code = 0;
            m_q.delete();
        end else if (start) begin
            m_rem   = sync_ab ? longint'(cnt_c) : longint'(cnt_b) * longint'(cnt_c);
            m_fin   = fin_en; m_mid = mid_en; m_early = early_en; m_code = code;
            m_q.delete();
        end else begin
            if (!m_early && req_cmp && m_q.size() > 0) begin
                f = m_q.pop_front();
                v = f ? m_fin : m_mid;
            end
            if (req_sub && m_rem > 0) begin
                f = (m_rem == 1);
                m_rem = m_rem - 1;
                if (m_early) v = f ? m_fin : m_mid;
                else if (m_q.size() < DEPTH) m_q.push_back(f);
            end
        end
        exp_v <= v;
        exp_c <= v ? m_code : 0;
    end

    // Compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            tests++;
            if (evt_valid !== exp_v || evt_code !== 6'(exp_c)) begin
                fails++;
                $display("FAIL %s: evt_valid/code actual %0b/%0d expected %0b/%0d at %0t",
                         tag, evt_valid, evt_code, exp_v, exp_c, $time);
            end
            if (evt_valid === 1'b1) evt_cnt++;
        end
    end

    task automatic drive(input bit s, input bit c);
        @(negedge clk); #1;
        start = 0; req_sub = s; req_cmp = c;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(0, 0);
    endtask

    task automatic arm(input bit ab, input int b, input int c, input bit f,
                       input bit m, input bit e, input int cd);
        @(negedge clk); #1;
        start = 1; sync_ab = ab; cnt_b = 16'(b); cnt_c = 16'(c);
        fin_en = f; mid_en = m; early_en = e; code = 6'(cd);
        req_sub = 0; req_cmp = 0;
        @(negedge clk); #1;
        start = 0;
        evt_cnt = 0;
    endtask

    task automatic check_count(input string t, input int expv);
        idle(3);
        tests++;
        if (evt_cnt != expv) begin
            fails++;
            $display("FAIL %s: event count actual %0d expected %0d", t, evt_cnt, expv);
        end
    endtask

    task automatic early_run(input bit ab, input bit f, input bit m, input int cd,
                             input int subs, input int expv, input string t);
        tag = t;
        arm(ab, 4, 5, f, m, 1, cd);
        for (int i = 0; i < subs; i++) begin
            drive(1, i % 3 == 0);
            drive(0, 0);
        end
        check_count(t, expv);
    endtask

    task automatic norm_run(input bit f, input bit m, input int cd, input int expv,
                            input string t);
        tag = t;
        arm(1, 4, 5, f, m, 0, cd);
        drive(1, 0); drive(1, 0); drive(1, 0);
        drive(0, 1);
        drive(1, 1); drive(1, 1);
        drive(0, 1); drive(0, 1); drive(0, 1);
        drive(0, 1); drive(1, 0);
        check_count(t, expv);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        tag = "R1";
        tests++;
        if (evt_valid !== 1'b0 || evt_code !== 6'd0) begin
            fails++;
            $display("FAIL R1: reset outputs actual %0b/%0d expected 0/0", evt_valid, evt_code);
        end
        #1 rst_n = 1;
        idle(2);

        // R2 R3 R6 R10: array mode, final only, extra submissions ignored
        early_run(0, 1, 0, 30, 22, 1, "R3");
        // R4: intermediate only
        early_run(0, 0, 1, 63, 20, 19, "R4");
        // R5 R2: both
        early_run(0, 1, 1, 17, 21, 20, "R5");
        // R2 frame mode early
        early_run(1, 1, 1, 5, 7, 5, "R2");
        // R7 R8: normal mode with interleaved and simultaneous strobes
        norm_run(1, 1, 42, 5, "R7");
        norm_run(1, 0, 1, 1, "R3");
        norm_run(0, 1, 0, 4, "R4");

        // R9: zero counts
        tag = "R9";
        arm(0, 0, 5, 1, 1, 1, 9);
        for (int i = 0; i < 4; i++) drive(1, 1);
        check_count("R9", 0);
        arm(1, 7, 0, 1, 1, 0, 9);
        for (int i = 0; i < 4; i++) drive(1, 1);
        check_count("R9", 0);

        // R10: completion with nothing outstanding
        tag = "R10";
        arm(1, 1, 2, 1, 1, 0, 12);
        drive(0, 1); drive(0, 1);
        drive(1, 0); drive(0, 1); drive(0, 1);
        check_count("R10", 1);

        // R11: restart with requests outstanding, strobe on the start cycle
        tag = "R11";
        arm(1, 1, 3, 1, 1, 0, 20);
        drive(1, 0); drive(1, 0);
        @(negedge clk); #1;
        start = 1; sync_ab = 1; cnt_c = 16'd2; code = 6'd33; req_sub = 1; req_cmp = 1;
        @(negedge clk); #1;
        start = 0; req_sub = 0; req_cmp = 0;
        evt_cnt = 0;
        drive(0, 1); drive(0, 1);
        drive(1, 0); drive(1, 0); drive(0, 1); drive(0, 1);
        check_count("R11", 2);

        // R6: completions in early mode do nothing
        tag = "R6";
        arm(1, 1, 3, 1, 1, 1, 50);
        for (int i = 0; i < 5; i++) drive(0, 1);
        check_count("R6", 0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            tests++;
            fails++;
            $display("FAIL %s: watchdog actual expired expected finish", tag);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule